// File: doc/BRIEF.md
# Memory Block Write-Readback Tester

This block exercises an external memory through the user-side port of a memory controller. It works on one window of 256 consecutive word addresses at a time. It writes pseudo-random 32-bit words into the window and keeps a copy of each word in a local reference buffer. It then reads the window back into a second local buffer and compares the two buffers index by index. After each window, the base moves up by 256 words. When the base runs past the top of the address space, it returns to zero and the sweep starts again. The tester runs without stopping, so it can be left going for long soak tests.

The controller side is a plain request/acknowledge port. A command carries a write flag, a word address and write data, and it is accepted when `cmd_valid_o` and `cmd_ready_i` are both high at a clock edge. Read data comes back in order on `rd_valid_i`. The latency is arbitrary, and the tester counts returned words instead of timing them. Results appear as a sticky fail flag, a saturating error count, a capture of the first failing address with its expected and actual words, and a sweep-complete pulse with a sweep counter.

Top module: `mem_window_tester`

## Requirements
- R1: While `rst_ni` is low, and after its release until `start_i` is seen high, no command is issued. In that time `busy_o`, `fail_o`, `err_cnt_o`, `sweep_cnt_o` and `sweep_done_o` are all zero.
- R2: Write data follows a Galois LFSR that shifts right. The next state is `(s >> 1) ^ (s[0] ? 32'h80200003 : 0)`, which corresponds to taps 32, 22, 2 and 1. Write number k since reset carries the state after k steps from the seed 32'h12345678, so the first word written is the seed itself. The sequence runs on across windows and is never reseeded.
- R3: In each window, 256 write commands (`cmd_we_o`=1) go out at addresses base+0 to base+255 in ascending order. A command that is pending (valid high, ready low) keeps its valid, flag, address and data unchanged until it is accepted.
- R4: Read commands (`cmd_we_o`=0) for the same 256 addresses, in ascending order, start only after the window's last write has been accepted.
- R5: Returned words are stored in order of arrival. The tester waits for exactly 256 returns whatever the latency. A pulse on `rd_valid_i` while no read phase is active is ignored.
- R6: The first write of the next window is issued only after all 256 returns of the current window have been received and compared.
- R7: Every index whose returned word differs from the written word adds one to `err_cnt_o`, which saturates at its maximum. `fail_o` is set by the first mismatch and then stays high.
- R8: `err_addr_o`, `err_exp_o` and `err_act_o` capture the absolute address, the written word and the returned word of the first mismatch, in ascending index order. Later mismatches leave them unchanged.
- R9: The base rises by 256 words per window. After the window that ends at the top of the address space, the base returns to zero. `sweep_done_o` then pulses for one cycle, together with the first write command of the new sweep at address 0, and `sweep_cnt_o` increments. The sweeps go on without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts testing from the idle state |
| cmd_valid_o | output | 1 | Command request |
| cmd_ready_i | input | 1 | Command accepted by controller |
| cmd_we_o | output | 1 | 1 = write, 0 = read |
| cmd_addr_o | output | ADDR_W | Word address |
| cmd_wdata_o | output | 32 | Write data |
| rd_valid_i | input | 1 | Read data return strobe |
| rd_data_i | input | 32 | Returned read word |
| busy_o | output | 1 | Tester has left idle |
| fail_o | output | 1 | Sticky mismatch flag |
| err_cnt_o | output | ERR_W | Saturating mismatch count |
| err_addr_o | output | ADDR_W | Address of first mismatch |
| err_exp_o | output | 32 | Expected word at first mismatch |
| err_act_o | output | 32 | Returned word at first mismatch |
| sweep_done_o | output | 1 | One-cycle pulse when a full sweep completes |
| sweep_cnt_o | output | SWEEP_W | Completed sweep count |

## Verification
The assertions assume that the controller returns no more reads than were issued and returns them in order, and that `rd_valid_i` pulses outside a read phase may be discarded. The bench memory model keeps a FIFO of accepted read addresses and answers only from it, with a stalling pattern on both `cmd_ready_i` and the return strobe. It injects stray return pulses only while writes are pending. To reach counter saturation and wraparound in a few thousand cycles, it runs a 1024-word space with a 4-bit error counter, and it corrupts chosen returns so that the first-error capture and the saturation can be predicted exactly.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] LFSR_MASK = 32'h8020_0003;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_CHECK
  } tst_state_e;
endpackage

// File: rtl/mbt_lfsr.sv
module mbt_lfsr import mbt_pkg::*; #(
  parameter logic [DATA_W-1:0] SEED = 32'h1234_5678
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [DATA_W-1:0] state_o
);
  logic [DATA_W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (step_i) s_q <= (s_q >> 1) ^ (s_q[0] ? LFSR_MASK : '0);
  end

  assign state_o = s_q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) s_q != '0);
endmodule

// File: rtl/mbt_win_buf.sv
module mbt_win_buf #(
  parameter int DEPTH_LG2 = 8,
  parameter int W         = 32
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [DEPTH_LG2-1:0] waddr_i,
  input  logic [W-1:0]         wdata_i,
  input  logic [DEPTH_LG2-1:0] raddr_i,
  output logic [W-1:0]         rdata_o
);
  localparam int DEPTH = 1 << DEPTH_LG2;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mbt_seq.sv
module mbt_seq import mbt_pkg::*; #(
  parameter int ADDR_W  = 20,
  parameter int WIN_LG2 = 8,
  parameter int SWEEP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cmd_ready_i,
  input  logic               rd_valid_i,
  output logic               cmd_valid_o,
  output logic               cmd_we_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [WIN_LG2-1:0] idx_o,
  output logic               wr_fire_o,
  output logic               cap_fire_o,
  output logic [WIN_LG2-1:0] cap_idx_o,
  output logic               cmp_en_o,
  output logic               busy_o,
  output logic               sweep_done_o,
  output logic [SWEEP_W-1:0] sweep_cnt_o
);
  localparam int PASS_W = ADDR_W - WIN_LG2;
  localparam logic [WIN_LG2:0] RCV_FULL = {1'b1, {WIN_LG2{1'b0}}};

  tst_state_e         state_q;
  logic [WIN_LG2-1:0] idx_q;
  logic [WIN_LG2:0]   rcv_q;
  logic               iss_done_q;
  logic [PASS_W-1:0]  pass_q;
  logic [SWEEP_W-1:0] sweep_cnt_q;
  logic               sweep_done_q;
  logic               hs;
  logic               idx_last;

  assign idx_last    = &idx_q;
  assign cmd_valid_o = (state_q == ST_WRITE) || (state_q == ST_READ && !iss_done_q);
  assign cmd_we_o    = (state_q == ST_WRITE);
  assign cmd_addr_o  = {pass_q, idx_q};
  assign hs          = cmd_valid_o && cmd_ready_i;
  assign wr_fire_o   = hs && cmd_we_o;
  assign cap_fire_o  = (state_q == ST_READ) && rd_valid_i && !rcv_q[WIN_LG2];
  assign cap_idx_o   = rcv_q[WIN_LG2-1:0];
  assign cmp_en_o    = (state_q == ST_CHECK);
  assign idx_o       = idx_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign sweep_done_o = sweep_done_q;
  assign sweep_cnt_o  = sweep_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      rcv_q        <= '0;
      iss_done_q   <= 1'b0;
      pass_q       <= '0;
      sweep_cnt_q  <= '0;
      sweep_done_q <= 1'b0;
    end else begin
      sweep_done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_WRITE;
        ST_WRITE: if (hs) begin
          idx_q <= idx_q + 1'b1;
          if (idx_last) begin
            state_q    <= ST_READ;
            iss_done_q <= 1'b0;
            rcv_q      <= '0;
          end
        end
        ST_READ: begin
          if (hs) begin
            idx_q <= idx_q + 1'b1;
            if (idx_last) iss_done_q <= 1'b1;
          end
          if (cap_fire_o) rcv_q <= rcv_q + 1'b1;
          if (rcv_q == RCV_FULL) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          idx_q <= idx_q + 1'b1;
          if (idx_last) begin
            state_q <= ST_WRITE;
            pass_q  <= pass_q + 1'b1;
            if (&pass_q) begin
              sweep_done_q <= 1'b1;
              sweep_cnt_q  <= sweep_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_we_o));
  // R4
  read_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ && $past(state_q) == ST_WRITE) |-> $past(cmd_ready_i && idx_last));
  // R6
  check_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK) |-> rcv_q[WIN_LG2]);
  // R9
  sweep_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_done_q |-> (cmd_addr_o == '0) && cmd_we_o && cmd_valid_o);
endmodule

// File: rtl/mbt_err.sv
module mbt_err import mbt_pkg::*; #(
  parameter int ADDR_W = 20,
  parameter int ERR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_en_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] act_i,
  output logic              fail_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_act_o
);
  logic              fail_q;
  logic [ERR_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q, act_q;
  logic              miss;

  assign miss = cmp_en_i && (exp_i != act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      exp_q  <= '0;
      act_q  <= '0;
    end else if (miss) begin
      if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
      if (!fail_q) begin
        fail_q <= 1'b1;
        addr_q <= cmp_addr_i;
        exp_q  <= exp_i;
        act_q  <= act_i;
      end
    end
  end

  assign fail_o     = fail_q;
  assign err_cnt_o  = cnt_q;
  assign err_addr_o = addr_q;
  assign err_exp_o  = exp_q;
  assign err_act_o  = act_q;

  // R7
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) fail_q |=> fail_q);
  // R7
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> cnt_q >= $past(cnt_q));
  // R7
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) fail_q |-> cnt_q != '0);
  // R8
  first_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> $stable(addr_q) && $stable(exp_q) && $stable(act_q));
endmodule

// File: rtl/mem_window_tester.sv
module mem_window_tester import mbt_pkg::*; #(
  parameter int                ADDR_W  = 20,
  parameter int                WIN_LG2 = 8,
  parameter int                ERR_W   = 16,
  parameter int                SWEEP_W = 16,
  parameter logic [DATA_W-1:0] SEED    = 32'h1234_5678
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic               cmd_we_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [DATA_W-1:0]  cmd_wdata_o,
  input  logic               rd_valid_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               busy_o,
  output logic               fail_o,
  output logic [ERR_W-1:0]   err_cnt_o,
  output logic [ADDR_W-1:0]  err_addr_o,
  output logic [DATA_W-1:0]  err_exp_o,
  output logic [DATA_W-1:0]  err_act_o,
  output logic               sweep_done_o,
  output logic [SWEEP_W-1:0] sweep_cnt_o
);
  logic               wr_fire, cap_fire, cmp_en;
  logic [WIN_LG2-1:0] idx, cap_idx;
  logic [DATA_W-1:0]  ref_rd, rb_rd, lfsr;

  mbt_seq #(.ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2), .SWEEP_W(SWEEP_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .cmd_ready_i, .rd_valid_i,
    .cmd_valid_o, .cmd_we_o, .cmd_addr_o,
    .idx_o(idx), .wr_fire_o(wr_fire), .cap_fire_o(cap_fire), .cap_idx_o(cap_idx),
    .cmp_en_o(cmp_en), .busy_o, .sweep_done_o, .sweep_cnt_o
  );

  mbt_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i, .rst_ni, .step_i(wr_fire), .state_o(lfsr)
  );

  assign cmd_wdata_o = lfsr;

  // reference copy of written words
  mbt_win_buf #(.DEPTH_LG2(WIN_LG2), .W(DATA_W)) u_ref (
    .clk_i, .we_i(wr_fire), .waddr_i(idx), .wdata_i(lfsr),
    .raddr_i(idx), .rdata_o(ref_rd)
  );

  // readback copy, filled in arrival order
  mbt_win_buf #(.DEPTH_LG2(WIN_LG2), .W(DATA_W)) u_rb (
    .clk_i, .we_i(cap_fire), .waddr_i(cap_idx), .wdata_i(rd_data_i),
    .raddr_i(idx), .rdata_o(rb_rd)
  );

  mbt_err #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_err (
    .clk_i, .rst_ni, .cmp_en_i(cmp_en), .cmp_addr_i(cmd_addr_o),
    .exp_i(ref_rd), .act_i(rb_rd),
    .fail_o, .err_cnt_o, .err_addr_o, .err_exp_o, .err_act_o
  );
endmodule

// File: tb/sim_mem_window_tester.sv
module sim_mem_window_tester;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 10;
  localparam int WIN     = 256;
  localparam int NPASS   = (1 << ADDR_W) / WIN;
  localparam int ERR_W   = 4;
  localparam int SWEEP_W = 4;
  localparam logic [31:0] CORRUPT = 32'h0000_0100;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic               cmd_valid_o, cmd_ready_i = 1'b0, cmd_we_o;
  logic [ADDR_W-1:0]  cmd_addr_o;
  logic [31:0]        cmd_wdata_o;
  logic               rd_valid_i = 1'b0;
  logic [31:0]        rd_data_i = '0;
  logic               busy_o, fail_o, sweep_done_o;
  logic [ERR_W-1:0]   err_cnt_o;
  logic [ADDR_W-1:0]  err_addr_o;
  logic [31:0]        err_exp_o, err_act_o;
  logic [SWEEP_W-1:0] sweep_cnt_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  mem_window_tester #(.ADDR_W(ADDR_W), .WIN_LG2(8), .ERR_W(ERR_W), .SWEEP_W(SWEEP_W)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .cmd_valid_o, .cmd_ready_i, .cmd_we_o,
    .cmd_addr_o, .cmd_wdata_o, .rd_valid_i, .rd_data_i, .busy_o, .fail_o,
    .err_cnt_o, .err_addr_o, .err_exp_o, .err_act_o, .sweep_done_o, .sweep_cnt_o
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  logic [31:0] mem [0:(1<<ADDR_W)-1];
  int fifo [0:511];

  initial begin
    automatic int head = 0, tail = 0;
    automatic int wcount = 0, rcount = 0, rets = 0, cyc = 0, sweeps = 0;
    automatic logic [31:0] exp_lfsr = 32'h1234_5678;
    automatic logic [31:0] err_word = '0;
    automatic bit pv = 0, pr = 0, pwe = 0;
    automatic logic [ADDR_W-1:0] paddr = '0;
    automatic logic [31:0] pdata = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !busy_o && !fail_o && err_cnt_o == 0 && sweep_cnt_o == 0 && !sweep_done_o,
        "R1 reset", {cmd_valid_o, busy_o, fail_o, sweep_done_o}, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(!cmd_valid_o && !busy_o, "R1 idle before start", {cmd_valid_o, busy_o}, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && cmd_valid_o && cmd_we_o && cmd_addr_o == 0, "R1 start", cmd_addr_o, 0);
    chk(cmd_wdata_o == 32'h1234_5678, "R2 first word is seed", cmd_wdata_o, 32'h1234_5678);

    while (sweeps < 3) begin
      automatic bit rdy;
      automatic logic [31:0] ret;
      // R3: pending command holds
      if (pv && !pr)
        chk(cmd_valid_o && cmd_addr_o == paddr && cmd_we_o == pwe && (!pwe || cmd_wdata_o == pdata),
            "R3 hold", cmd_addr_o, paddr);
      // R9: sweep completion pulse
      if (sweep_done_o) begin
        sweeps++;
        chk(cmd_valid_o && cmd_we_o && cmd_addr_o == 0, "R9 wrap to zero", cmd_addr_o, 0);
        chk(sweep_cnt_o == SWEEP_W'(sweeps), "R9 sweep count", sweep_cnt_o, sweeps);
        chk(wcount == sweeps * NPASS * WIN, "R9 sweep length", wcount, sweeps * NPASS * WIN);
        if (sweeps == 1) chk(!fail_o && err_cnt_o == 0, "R7 clean sweep", err_cnt_o, 0);
        if (sweeps == 2) begin
          chk(fail_o && err_cnt_o == 2, "R7 two mismatches", err_cnt_o, 2);
          chk(err_addr_o == ADDR_W'(WIN + 5), "R8 first addr", err_addr_o, WIN + 5);
          chk(err_exp_o == err_word, "R8 first expected", err_exp_o, err_word);
          chk(err_act_o == (err_word ^ CORRUPT), "R8 first actual", err_act_o, err_word ^ CORRUPT);
        end
        if (sweeps == 3) begin
          chk(err_cnt_o == {ERR_W{1'b1}}, "R7 saturation", err_cnt_o, {ERR_W{1'b1}});
          chk(fail_o, "R7 sticky fail", fail_o, 1);
          chk(err_addr_o == ADDR_W'(WIN + 5) && err_exp_o == err_word, "R8 capture held", err_addr_o, WIN + 5);
        end
      end
      // read return model: answer only issued reads, with gaps
      rd_valid_i = 1'b0;
      rd_data_i  = '0;
      if (head != tail && (cyc % 4) != 1) begin
        ret = mem[fifo[head]];
        if ((rets / WIN == 5 && rets % WIN == 5) || (rets / WIN == 6 && rets % WIN == 9) || rets / WIN == 8)
          ret = ret ^ CORRUPT;
        rd_valid_i = 1'b1;
        rd_data_i  = ret;
        head = (head + 1) % 512;
        rets++;
      end else if (cmd_valid_o && cmd_we_o && (cyc % 7) == 3) begin
        rd_valid_i = 1'b1;          // R5: stray pulse outside read phase
        rd_data_i  = 32'hDEAD_BEEF;
      end
      rdy = ((cyc % 3) != 2) && ((cyc % 11) != 0);
      cmd_ready_i = rdy;
      if (cmd_valid_o && rdy) begin
        if (cmd_we_o) begin
          if (wcount % WIN == 0)
            chk(rets == wcount, "R6 compare before next window", rets, wcount);
          chk(int'(cmd_addr_o) == ((wcount / WIN) % NPASS) * WIN + wcount % WIN,
              "R3 write addr", cmd_addr_o, ((wcount / WIN) % NPASS) * WIN + wcount % WIN);
          chk(cmd_wdata_o == exp_lfsr, "R2 write data", cmd_wdata_o, exp_lfsr);
          mem[cmd_addr_o] = cmd_wdata_o;
          if (wcount == 5 * WIN + 5) err_word = cmd_wdata_o;
          exp_lfsr = lfsr_next(exp_lfsr);
          wcount++;
        end else begin
          chk(wcount == (rcount / WIN + 1) * WIN, "R4 reads after writes", wcount, (rcount / WIN + 1) * WIN);
          chk(int'(cmd_addr_o) == ((rcount / WIN) % NPASS) * WIN + rcount % WIN,
              "R4 read addr", cmd_addr_o, ((rcount / WIN) % NPASS) * WIN + rcount % WIN);
          fifo[tail] = int'(cmd_addr_o);
          tail = (tail + 1) % 512;
          rcount++;
        end
      end
      pv = cmd_valid_o; pr = rdy; pwe = cmd_we_o; paddr = cmd_addr_o; pdata = cmd_wdata_o;
      cyc++;
      @(negedge clk);
    end
    // R5: 256 returns per window, stray pulses absorbed
    chk(rets == rcount, "R5 return count", rets, rcount);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule